// File: doc/BRIEF.md
# Operation Sampling Interval Selector

This block decides which operations in a stream of retiring or issuing operations are chosen for profiling. A down-counter advances once for every valid operation. When it runs out, that same operation is selected and the counter is reloaded from the programmed interval. The programmed interval is replaced by a minimum interval when it is zero, and it may be perturbed by a pseudo-random value so that sampling does not lock onto a loop's period.

Only one selected operation may be outstanding at a time. A busy flag records that a selected operation has not yet reported completion. If the counter runs out while that flag is set, the selection is dropped. The block raises a collision pulse and increments a collision counter. A population counter counts every operation seen while the block is enabled. A synchronous enable gates all of this activity.

Top module: `op_sample_selector`

## Requirements
- R1: While `enable` is high, every cycle with `op_valid` high decrements the countdown by one. A valid operation arriving when the countdown is 1 or less selects that operation. `sample_sel` pulses in that same cycle, and the countdown reloads.
- R2: The reload base is `interval`, or `min_interval` when `interval` is zero. The reload value is never below `min_interval`, and never below 1.
- R3: A 16-bit shift register generates the perturbation. It is seeded with 0xACE1, shifts left, and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10. It steps once on every countdown expiry. When `jitter_en` is high, its bits 7:0 are XORed into bits 7:0 of the reload base before the floor of R2 is applied. When `jitter_en` is low, the base is used unchanged.
- R4: `busy` rises in the cycle after a `sample_sel` pulse. It falls in the cycle after `op_done` when no new selection occurs.
- R5: An expiry while `busy` is high and `op_done` is low produces a `collision` pulse and no `sample_sel`. `busy` stays high.
- R6: When an expiry and `op_done` fall in the same cycle, the completion is applied first, so the selection is accepted. `sample_sel` pulses and `busy` stays high.
- R7: `coll_count` increments by one after each `collision` pulse and wraps at its width.
- R8: `pop_count` increments by one after each cycle with `enable` and `op_valid` both high.
- R9: While `enable` is low, no pulse is produced and neither counter moves. `busy` clears on the next edge, and the countdown is loaded with the reload value on every edge.
- R10: After reset, `sample_sel`, `collision`, `busy`, `coll_count` and `pop_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous enable for all counting |
| op_valid | input | 1 | An operation of the sample population is present |
| op_done | input | 1 | The outstanding selected operation has completed |
| interval | input | CNT_W | Programmed sampling interval; zero selects the minimum |
| min_interval | input | CNT_W | Minimum interval and reload floor |
| jitter_en | input | 1 | Apply pseudo-random perturbation to reloads |
| sample_sel | output | 1 | The current operation is selected |
| collision | output | 1 | A selection was dropped because one is outstanding |
| busy | output | 1 | A selected operation is outstanding |
| coll_count | output | COUNT_W | Number of collisions |
| pop_count | output | COUNT_W | Number of population operations |

## Verification
Countdown expiry and completion of the outstanding operation can land in the same cycle, and the result depends on which of the two is applied first. The bench provokes this in two ways. In a directed phase, the interval is forced to 1 and `op_done` is held high on every cycle, so each expiry coincides with a completion. In random phases, `op_done` is toggled freely. The behavioural model applies completion before the new selection. It then judges `sample_sel`, `collision` and `busy` against the model on every cycle, so an ordering error shows up as a false collision or a lost selection.

// File: rtl/op_sample_selector.sv
module op_sample_selector #(
  parameter int CNT_W = 16,
  parameter int COUNT_W = 32,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               op_valid,
  input  logic               op_done,
  input  logic [CNT_W-1:0]   interval,
  input  logic [CNT_W-1:0]   min_interval,
  input  logic               jitter_en,
  output logic               sample_sel,
  output logic               collision,
  output logic               busy,
  output logic [COUNT_W-1:0] coll_count,
  output logic [COUNT_W-1:0] pop_count
);
  localparam int JW = (CNT_W < 8) ? CNT_W : 8;

  logic [CNT_W-1:0] cnt, base, jit, floor_v, reload;
  logic [15:0] lfsr;
  logic expire, hold;

  assign base    = (interval == '0) ? min_interval : interval;
  assign jit     = jitter_en ? (base ^ CNT_W'(lfsr[JW-1:0])) : base;
  assign floor_v = (min_interval == '0) ? CNT_W'(1) : min_interval;
  assign reload  = (jit < floor_v) ? floor_v : jit;

  assign expire     = enable && op_valid && (cnt <= CNT_W'(1));
  assign hold       = busy && !op_done;
  assign sample_sel = expire && !hold;
  assign collision  = expire && hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable) begin
      cnt <= reload;
    end else if (op_valid) begin
      cnt <= expire ? reload : cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lfsr <= LFSR_SEED;
    else if (expire)
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= 1'b0;
    else if (!enable)    busy <= 1'b0;
    else if (sample_sel) busy <= 1'b1;
    else if (op_done)    busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_count <= '0;
      pop_count  <= '0;
    end else begin
      if (collision)           coll_count <= coll_count + COUNT_W'(1);
      if (enable && op_valid)  pop_count  <= pop_count + COUNT_W'(1);
    end
  end
endmodule

module op_sample_selector_chk #(
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               op_valid,
  input logic               op_done,
  input logic               sample_sel,
  input logic               collision,
  input logic               busy,
  input logic [COUNT_W-1:0] coll_count,
  input logic [COUNT_W-1:0] pop_count
);
  p_sel_needs_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_sel |-> (enable && op_valid));
  p_busy_after_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_sel |=> busy);
  p_coll_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (busy && !op_done && !sample_sel));
  p_coll_keeps_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> busy);
  p_coll_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> (coll_count == $past(coll_count) + COUNT_W'(1)));
  p_coll_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !collision |=> $stable(coll_count));
  p_pop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && op_valid) |=> (pop_count == $past(pop_count) + COUNT_W'(1)));
  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!sample_sel && !collision));
  p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
endmodule

bind op_sample_selector op_sample_selector_chk #(.COUNT_W(COUNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .op_valid(op_valid),
  .op_done(op_done), .sample_sel(sample_sel), .collision(collision),
  .busy(busy), .coll_count(coll_count), .pop_count(pop_count)
);

// File: tb/op_sample_selector_tb.sv
module op_sample_selector_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, op_valid = 0, op_done = 0, jitter_en = 0;
  logic [15:0] interval = '0, min_interval = '0;
  logic sample_sel, collision, busy;
  logic [31:0] coll_count, pop_count;

  always #2 clk = ~clk;

  op_sample_selector dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .op_valid(op_valid),
    .op_done(op_done), .interval(interval), .min_interval(min_interval),
    .jitter_en(jitter_en), .sample_sel(sample_sel), .collision(collision),
    .busy(busy), .coll_count(coll_count), .pop_count(pop_count));

  int checks = 0, errors = 0;
  int m_cnt = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  bit m_busy = 0;
  logic [31:0] m_coll = 0, m_pop = 0;
  int n_sel = 0, n_coll = 0, n_tie = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int reload_val();
    int b, j, f;
    b = (interval == 0) ? int'(min_interval) : int'(interval);
    j = jitter_en ? (b ^ int'(m_lfsr[7:0])) : b;
    f = (min_interval == 0) ? 1 : int'(min_interval);
    return (j < f) ? f : j;
  endfunction

  // compare at negedge+1, then advance the model to the state after the next posedge
  task automatic cycle(string tag);
    bit exp_e, exp_sel, exp_col;
    #1;
    exp_e = enable && op_valid && (m_cnt <= 1);
    exp_sel = exp_e && !(m_busy && !op_done);
    exp_col = exp_e && m_busy && !op_done;
    chk({"R1 sample_sel ", tag}, sample_sel, exp_sel);
    chk({"R5 collision ", tag}, collision, exp_col);
    chk({"R4 busy ", tag}, busy, m_busy);
    chk({"R7 coll_count ", tag}, coll_count, m_coll);
    chk({"R8 pop_count ", tag}, pop_count, m_pop);
    if (exp_sel) n_sel++;
    if (exp_col) n_coll++;
    if (exp_sel && m_busy && op_done) n_tie++;
    if (!enable) begin
      m_cnt = reload_val();
      m_busy = 0;
    end else begin
      if (op_valid) begin
        if (m_cnt <= 1) begin
          m_cnt = reload_val();
          m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end else m_cnt--;
        m_pop++;
      end
      if (exp_sel) m_busy = 1;
      else if (op_done) m_busy = 0;
      if (exp_col) m_coll++;
    end
    @(negedge clk);
  endtask

  task automatic phase(string tag, int n, int iv, int mn, bit jit,
                       int pv, int pd, int pe);
    interval = 16'(iv); min_interval = 16'(mn); jitter_en = jit;
    for (int i = 0; i < n; i++) begin
      enable = ($urandom_range(99) < pe);
      op_valid = ($urandom_range(99) < pv);
      op_done = ($urandom_range(99) < pd);
      cycle(tag);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    chk("R10 sample_sel", sample_sel, 0);
    chk("R10 collision", collision, 0);
    chk("R10 busy", busy, 0);
    chk("R10 coll_count", coll_count, 0);
    chk("R10 pop_count", pop_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    enable = 0; interval = 5; min_interval = 2;
    cycle("R9 preload");
    // R1: exact period 5, one op per cycle, completion immediately after
    phase("R1 fixed", 60, 5, 2, 0, 100, 100, 100);
    // R2: zero interval uses minimum; interval below minimum clamps
    phase("R2 zero", 80, 0, 3, 0, 100, 50, 100);
    phase("R2 floor", 80, 2, 6, 0, 80, 50, 100);
    phase("R2 both zero", 40, 0, 0, 0, 100, 100, 100);
    // R3: jitter perturbs reload
    phase("R3 jitter", 800, 40, 4, 1, 90, 60, 100);
    phase("R3 jitter floor", 400, 3, 20, 1, 90, 60, 100);
    // R5/R7: rare completion forces collisions
    phase("R5 collide", 300, 2, 1, 0, 100, 3, 100);
    // R6: every op expires and completion present each cycle
    phase("R6 tie", 100, 1, 0, 0, 100, 100, 100);
    // R9: enable toggling
    phase("R9 gate", 600, 3, 1, 1, 70, 30, 60);
    // mixed
    phase("R8 mixed", 1500, 4, 2, 1, 60, 40, 90);
    chk("R1 selections seen", n_sel > 20, 1);
    chk("R5 collisions seen", n_coll > 5, 1);
    chk("R6 ties seen", n_tie > 5, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule